// File: doc/BRIEF.md
# Reset Source Controller

This block merges every reset cause of a small microcontroller into a single active-low reset line. It also keeps a small status record of which cause produced the most recent reset. The causes are:

- a power-on event;
- a supply-below-threshold comparator output, which passes through a synchronizer before use;
- a software reset request;
- an attempt to write or erase flash while the supply monitor is not guarding at its high level.

All causes restart the processor at the same address. Software can tell them apart only by reading the flag outputs.

The block also holds the supply-monitor configuration: an enable bit, a level bit and a bit that makes the monitor a reset source. A power-on forces this configuration back to its defaults. Every other reset leaves it as software last wrote it.

A power-on holds reset for as long as the power-on input is high and as long as the synchronized supply indication reads low. After that, reset stays asserted for a programmable number of clock cycles before it is released. A software or flash-error reset asserts the line for a fixed pulse length. A monitor reset holds the line until the supply recovers.

Top module: `rst_cause_ctrl`

## Requirements
- R1: With `por_i` low, once the synchronized supply indication reads good the controller counts POR_DELAY cycles and then raises `rst_n_o`. Take the first clock edge that samples `por_i` low with `vdd_low_i` already low as edge 0. `rst_n_o` is low after edges 0 to POR_DELAY+1 and high after edge POR_DELAY+2.
- R2: After a power-on the flags read power-on=1, monitor=0, flash=0, software=0. The configuration reads enable=1, high-level=0, source-select=1.
- R3: When enable and source-select are both 1, a `vdd_low_i` rise takes `rst_n_o` low after the third clock edge that samples it (two synchronizer stages plus the state register). The reset sets the monitor flag and clears the other three flags. `rst_n_o` returns high after the third edge that samples `vdd_low_i` low again.
- R4: A low supply causes no reset while enable=0, or while source-select=0.
- R5: A one-cycle `sw_rst_i` while running holds `rst_n_o` low for exactly PULSE_LEN cycles, starting after the sampling edge. It sets the software flag and clears the other three flags.
- R6: A `flash_wr_i` strobe while running gives a PULSE_LEN-cycle reset with only the flash flag set, unless enable, high-level and source-select are all 1. In that case the strobe has no effect.
- R7: The monitor configuration is unchanged by monitor, software and flash-error resets. A power-on restores the R2 defaults.
- R8: When several causes are sampled in the same running cycle, only one flag is set, by priority: monitor, then flash error, then software. Power-on overrides all of them at any time.
- R9: While `rst_n_o` is low, configuration writes, software requests and flash strobes are ignored. They neither change the configuration nor lengthen the reset.
- R10: If the supply indication goes low during the power-on delay, the controller returns to holding reset. The full POR_DELAY count starts again once the supply is good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on event, high while power is being applied; acts as the block's own synchronous reset |
| vdd_low_i | input | 1 | Asynchronous comparator output, 1 when the supply is below threshold |
| sw_rst_i | input | 1 | Software reset request strobe |
| flash_wr_i | input | 1 | Flash write or erase attempt strobe |
| cfg_we_i | input | 1 | Write strobe for the monitor configuration |
| cfg_en_i | input | 1 | Write data: monitor enable |
| cfg_hi_i | input | 1 | Write data: monitor high-level select |
| cfg_src_i | input | 1 | Write data: monitor selected as a reset source |
| rst_n_o | output | 1 | Active-low reset to the processor |
| flag_por_o | output | 1 | Last reset came from power-on |
| flag_mon_o | output | 1 | Last reset came from the supply monitor |
| flag_flash_o | output | 1 | Last reset came from a flash-error |
| flag_sw_o | output | 1 | Last reset came from a software request |
| mon_en_o | output | 1 | Current monitor enable |
| mon_hi_o | output | 1 | Current monitor high-level select |
| mon_src_o | output | 1 | Current monitor source select |

## Verification
A supply drop can reach the running state in the same cycle as a software request or a flash strobe. The bench provokes this by raising `vdd_low_i` two edges early, so that the synchronized copy arrives at the edge that also samples the other strobes. Only the monitor flag may then be set, and the reset must last until the supply recovers rather than one pulse length. The bench also checks a flash strobe against a software request in the same cycle, once with the flash gate closed and once with it open.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [2:0] {
        S_POR_HOLD,
        S_POR_DELAY,
        S_RUN,
        S_MON_HOLD,
        S_PULSE
    } seq_state_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_POR,
        C_MON,
        C_FLASH,
        C_SW
    } cause_e;

    typedef struct packed {
        logic sw;
        logic flash;
        logic mon;
        logic por;
    } cause_flags_t;

    typedef struct packed {
        logic src;
        logic hi;
        logic en;
    } mon_cfg_t;

    localparam mon_cfg_t CFG_AFTER_POR = '{src: 1'b1, hi: 1'b0, en: 1'b1};

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        if (rst_i) begin
            chain_d = {STAGES{RST_VAL}};
        end
    end

    always_ff @(posedge clk_i) begin
        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
    import rcc_pkg::*;
#(
    parameter int unsigned POR_DELAY = 256,
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic   clk_i,
    input  logic   por_i,
    input  logic   low_i,
    input  logic   trip_i,
    input  logic   flash_err_i,
    input  logic   sw_req_i,
    output logic   rst_n_o,
    output cause_e cause_o
);

    localparam int unsigned LONGEST = (POR_DELAY > PULSE_LEN) ? POR_DELAY : PULSE_LEN;
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(POR_DELAY - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        cause_o = C_NONE;
        if (por_i) begin
            r_d.state = S_POR_HOLD;
            r_d.cnt   = '0;
            cause_o   = C_POR;
        end else begin
            case (r_q.state)
                S_POR_HOLD: begin
                    if (!low_i) begin
                        r_d.state = S_POR_DELAY;
                        r_d.cnt   = '0;
                    end
                end
                S_POR_DELAY: begin
                    if (low_i) begin
                        r_d.state = S_POR_HOLD;
                    end else if (r_q.cnt == DELAY_LAST) begin
                        r_d.state = S_RUN;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                S_RUN: begin
                    r_d.cnt = '0;
                    if (trip_i) begin
                        r_d.state = S_MON_HOLD;
                        cause_o   = C_MON;
                    end else if (flash_err_i) begin
                        r_d.state = S_PULSE;
                        cause_o   = C_FLASH;
                    end else if (sw_req_i) begin
                        r_d.state = S_PULSE;
                        cause_o   = C_SW;
                    end
                end
                S_MON_HOLD: begin
                    if (!low_i) begin
                        r_d.state = S_RUN;
                    end
                end
                S_PULSE: begin
                    if (r_q.cnt == PULSE_LAST) begin
                        r_d.state = S_RUN;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                default: r_d.state = S_POR_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign rst_n_o = (r_q.state == S_RUN);

    // R1: a low supply while holding after power-on keeps reset asserted
    assert_hold_on_low_R1: assert property (@(posedge clk_i) disable iff (por_i)
        (r_q.state == S_POR_HOLD && low_i) |=> !rst_n_o);

    // R5: the pulse counter never runs past the pulse length
    assert_pulse_bound_R5: assert property (@(posedge clk_i) disable iff (por_i)
        (r_q.state == S_PULSE) |-> (r_q.cnt <= PULSE_LAST));

    // R10: a low supply during the delay keeps reset low next cycle
    assert_delay_abort_R10: assert property (@(posedge clk_i) disable iff (por_i)
        (r_q.state == S_POR_DELAY && low_i) |=> (!rst_n_o && r_q.cnt != DELAY_LAST + CNT_W'(1)));

endmodule

// File: rtl/rcc_status.sv
module rcc_status
    import rcc_pkg::*;
(
    input  logic         clk_i,
    input  logic         por_i,
    input  logic         run_i,
    input  cause_e       cause_i,
    input  logic         cfg_we_i,
    input  mon_cfg_t     cfg_wdata_i,
    output cause_flags_t flags_o,
    output mon_cfg_t     cfg_o
);

    typedef struct packed {
        cause_flags_t flags;
        mon_cfg_t     cfg;
    } status_regs_t;

    status_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cause_i != C_NONE) begin
            r_d.flags = '0;
            case (cause_i)
                C_POR:   r_d.flags.por   = 1'b1;
                C_MON:   r_d.flags.mon   = 1'b1;
                C_FLASH: r_d.flags.flash = 1'b1;
                C_SW:    r_d.flags.sw    = 1'b1;
                default: r_d.flags       = r_q.flags;
            endcase
        end
        if (por_i) begin
            r_d.cfg = CFG_AFTER_POR;
        end else if (cfg_we_i && run_i) begin
            r_d.cfg = cfg_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign flags_o = r_q.flags;
    assign cfg_o   = r_q.cfg;

    // R9: configuration frozen while the processor is held in reset
    assert_cfg_frozen_R9: assert property (@(posedge clk_i) disable iff (por_i)
        !run_i |=> $stable(r_q.cfg));

    // R7: a non-power-on reset leaves the configuration alone
    assert_cfg_kept_R7: assert property (@(posedge clk_i) disable iff (por_i)
        (cause_i != C_NONE && !cfg_we_i) |=> $stable(r_q.cfg));

    // R8: exactly one cause is recorded at any time after power-on
    assert_one_cause_R8: assert property (@(posedge clk_i) disable iff (por_i)
        $onehot(r_q.flags));

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned POR_DELAY   = 256,
    parameter int unsigned PULSE_LEN   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic vdd_low_i,
    input  logic sw_rst_i,
    input  logic flash_wr_i,
    input  logic cfg_we_i,
    input  logic cfg_en_i,
    input  logic cfg_hi_i,
    input  logic cfg_src_i,
    output logic rst_n_o,
    output logic flag_por_o,
    output logic flag_mon_o,
    output logic flag_flash_o,
    output logic flag_sw_o,
    output logic mon_en_o,
    output logic mon_hi_o,
    output logic mon_src_o
);

    logic         vdd_low_s;
    logic         mon_trip;
    logic         flash_ok;
    logic         flash_err;
    cause_e       cause;
    cause_flags_t flags;
    mon_cfg_t     cfg;
    mon_cfg_t     cfg_wdata;

    rcc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (por_i),
        .d_i   (vdd_low_i),
        .q_o   (vdd_low_s)
    );

    assign mon_trip  = cfg.en & cfg.src & vdd_low_s;
    assign flash_ok  = cfg.en & cfg.hi & cfg.src;
    assign flash_err = flash_wr_i & ~flash_ok;
    assign cfg_wdata = '{src: cfg_src_i, hi: cfg_hi_i, en: cfg_en_i};

    rcc_seq #(
        .POR_DELAY (POR_DELAY),
        .PULSE_LEN (PULSE_LEN)
    ) u_seq (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .low_i       (vdd_low_s),
        .trip_i      (mon_trip),
        .flash_err_i (flash_err),
        .sw_req_i    (sw_rst_i),
        .rst_n_o     (rst_n_o),
        .cause_o     (cause)
    );

    rcc_status u_status (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .run_i       (rst_n_o),
        .cause_i     (cause),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata),
        .flags_o     (flags),
        .cfg_o       (cfg)
    );

    assign flag_por_o   = flags.por;
    assign flag_mon_o   = flags.mon;
    assign flag_flash_o = flags.flash;
    assign flag_sw_o    = flags.sw;
    assign mon_en_o     = cfg.en;
    assign mon_hi_o     = cfg.hi;
    assign mon_src_o    = cfg.src;

    // R3: an armed monitor seeing a low supply drops reset next cycle
    assert_mon_trip_R3: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_n_o && mon_en_o && mon_src_o && vdd_low_s) |=> !rst_n_o);

    // R3: a monitor reset persists while the supply stays low
    assert_mon_hold_R3: assert property (@(posedge clk_i) disable iff (por_i)
        (!rst_n_o && flag_mon_o && vdd_low_s) |=> !rst_n_o);

    // R6: an unguarded flash strobe causes a reset
    assert_flash_gate_R6: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_n_o && flash_wr_i && !(mon_en_o && mon_hi_o && mon_src_o)) |=> !rst_n_o);

    // R6: a guarded flash strobe alone leaves the processor running
    assert_flash_pass_R6: assert property (@(posedge clk_i) disable iff (por_i)
        (rst_n_o && flash_wr_i && mon_en_o && mon_hi_o && mon_src_o
         && !sw_rst_i && !vdd_low_s) |=> rst_n_o);

endmodule

// File: tb/test_rst_cause_ctrl.sv
`timescale 1ns/1ps
module test_rst_cause_ctrl;

    localparam int unsigned D = 5;
    localparam int unsigned P = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic por = 1'b1, vdd_low = 1'b0, sw = 1'b0, fl = 1'b0;
    logic cwe = 1'b0, cen = 1'b0, chi = 1'b0, csrc = 1'b0;
    logic rst_n, f_por, f_mon, f_fl, f_sw, m_en, m_hi, m_src;

    rst_cause_ctrl #(.POR_DELAY(D), .PULSE_LEN(P), .SYNC_STAGES(2)) i_rst_cause_ctrl (
        .clk_i(clk), .por_i(por), .vdd_low_i(vdd_low), .sw_rst_i(sw), .flash_wr_i(fl),
        .cfg_we_i(cwe), .cfg_en_i(cen), .cfg_hi_i(chi), .cfg_src_i(csrc),
        .rst_n_o(rst_n), .flag_por_o(f_por), .flag_mon_o(f_mon), .flag_flash_o(f_fl),
        .flag_sw_o(f_sw), .mon_en_o(m_en), .mon_hi_o(m_hi), .mon_src_o(m_src)
    );

    typedef struct {
        string      req;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    logic [3:0] ef;  // {sw, flash, mon, por}
    logic [2:0] ec;  // {src, hi, en}

    // monitor: compare each queued expectation mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = {rst_n, f_sw, f_fl, f_mon, f_por, m_src, m_hi, m_en};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: got rst/flags/cfg=%b expected %b", it.req, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string req, logic r);
        item_t it;
        it.req = req;
        it.exp = {r, ef, ec};
        q.push_back(it);
    endtask

    task automatic write_cfg(logic en, logic hi, logic src);
        cwe = 1'b1; cen = en; chi = hi; csrc = src;
        tick();
        cwe = 1'b0;
        ec = {src, hi, en};
        expect_out("R9 cfg write", 1'b1);
    endtask

    // caller raises the request; this samples it and checks the pulse
    task automatic run_pulse(string req);
        tick();
        sw = 1'b0; fl = 1'b0;
        expect_out(req, 1'b0);
        repeat (P - 1) begin
            tick();
            expect_out(req, 1'b0);
        end
        tick();
        expect_out(req, 1'b1);
    endtask

    task automatic por_release(string req);
        for (int i = 0; i < D + 2; i++) begin
            tick();
            expect_out(req, 1'b0);
        end
        tick();
        expect_out(req, 1'b1);
    endtask

    task automatic finish_run();
        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no finish expected finish");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        ef = 4'b0001;
        ec = 3'b101;
        repeat (3) tick();
        expect_out("R2 reset state", 1'b0);

        // R1 R2: power-on release timing and flags
        por = 1'b0;
        por_release("R1 R2 por delay");

        // R3: monitor reset and release
        vdd_low = 1'b1;
        tick(); expect_out("R3 sync lag", 1'b1);
        tick(); expect_out("R3 sync lag", 1'b1);
        tick(); ef = 4'b0010; expect_out("R3 trip", 1'b0);
        repeat (3) begin tick(); expect_out("R3 hold", 1'b0); end
        vdd_low = 1'b0;
        tick(); expect_out("R3 release lag", 1'b0);
        tick(); expect_out("R3 release lag", 1'b0);
        tick(); expect_out("R3 release", 1'b1);

        // R6: flash strobe with the monitor at low level
        fl = 1'b1; ef = 4'b0100;
        run_pulse("R6 flash error");

        // R6: fully guarded, strobe has no effect
        write_cfg(1'b1, 1'b1, 1'b1);
        fl = 1'b1;
        tick(); fl = 1'b0; expect_out("R6 guarded", 1'b1);
        tick(); expect_out("R6 guarded", 1'b1);

        // R5: software reset
        sw = 1'b1; ef = 4'b1000;
        run_pulse("R5 software");

        // R9: requests and writes ignored during a pulse
        sw = 1'b1;
        tick(); sw = 1'b0; expect_out("R9 pulse start", 1'b0);
        cwe = 1'b1; cen = 1'b0; chi = 1'b0; csrc = 1'b0; sw = 1'b1; fl = 1'b1;
        tick(); cwe = 1'b0; sw = 1'b0; fl = 1'b0; expect_out("R9 ignored", 1'b0);
        tick(); expect_out("R9 ignored", 1'b0);
        tick(); expect_out("R9 ignored", 1'b0);
        tick(); expect_out("R9 not extended", 1'b1);

        // R7: configuration survives a software reset
        write_cfg(1'b0, 1'b0, 1'b0);
        sw = 1'b1;
        run_pulse("R7 cfg kept");

        // R4: monitor disabled, then enabled but not selected
        vdd_low = 1'b1;
        repeat (6) begin tick(); expect_out("R4 disabled", 1'b1); end
        vdd_low = 1'b0;
        repeat (3) tick();
        write_cfg(1'b1, 1'b0, 1'b0);
        vdd_low = 1'b1;
        repeat (6) begin tick(); expect_out("R4 not selected", 1'b1); end
        vdd_low = 1'b0;
        repeat (3) begin tick(); expect_out("R4 not selected", 1'b1); end

        // R8: monitor beats flash and software in the same cycle
        write_cfg(1'b1, 1'b0, 1'b1);
        vdd_low = 1'b1;
        tick(); expect_out("R8 pre", 1'b1);
        tick(); expect_out("R8 pre", 1'b1);
        sw = 1'b1; fl = 1'b1;
        tick(); sw = 1'b0; fl = 1'b0; ef = 4'b0010;
        expect_out("R8 monitor wins", 1'b0);
        vdd_low = 1'b0;
        tick(); expect_out("R8 monitor hold", 1'b0);
        tick(); expect_out("R8 monitor hold", 1'b0);
        tick(); expect_out("R8 monitor release", 1'b1);

        // R8: flash beats software
        sw = 1'b1; fl = 1'b1; ef = 4'b0100;
        run_pulse("R8 flash wins");

        // R8: with the gate open only software remains
        write_cfg(1'b1, 1'b1, 1'b1);
        sw = 1'b1; fl = 1'b1; ef = 4'b1000;
        run_pulse("R8 software only");

        // R7 R10: power-on restores defaults, supply drop during delay restarts
        write_cfg(1'b0, 1'b0, 1'b0);
        por = 1'b1; vdd_low = 1'b1;
        tick(); ef = 4'b0001; ec = 3'b101;
        expect_out("R7 por defaults", 1'b0);
        tick();
        por = 1'b0;
        repeat (4) begin tick(); expect_out("R10 supply low", 1'b0); end
        vdd_low = 1'b0;
        repeat (4) begin tick(); expect_out("R10 delay", 1'b0); end
        vdd_low = 1'b1;
        repeat (6) begin tick(); expect_out("R10 restart", 1'b0); end
        vdd_low = 1'b0;
        por_release("R10 full delay");

        finish_run();
    end

endmodule